// File: doc/BRIEF.md
# Shared-Bus Serial Result Port

This block is the output side of a data converter that can split one serial line with a second, identical converter. Each device puts out one 16-bit result per 32-clock frame. It shifts the result out in the first half of its own frame and releases the line in the second half. The device acting as master aligns its frame to an external frame-sync pulse. Its frame-sync output is wired to the frame-sync input of the second device. That output goes high just before the second half of the master frame, so the second device drives the line while the master is silent. Both devices restart their filters from the same edge, so the two results in one bus frame belong to the same sampling instant.

Results enter through a valid/ready stream. The port asks for a word with `smp_ready` for one cycle just before each frame begins. A word moves only on a clock edge where both `smp_valid` and `smp_ready` are high. A source that is not accepted must hold its word. If `smp_valid` is low at that edge, nothing is taken and the port leaves the line released for the whole coming slot.

Two inputs realign the frame. The frame-sync input acts only while it is armed. Reset arms it, and so does every resynchronise pulse. The first accepted frame-sync edge disarms it. The resynchronise input realigns the frame every time. Any realignment restarts the settling count of the abstract filter. Until that count runs out, the result is flagged invalid and the line stays released.

Top module: `shared_bus_serial_port`

## Requirements
- R1: A frame is 32 clocks long and begins in the cycle after the clock edge that samples an aligning event. The device's slot is frame cycles 0 to 15. In slot cycle k, `sdo` carries bit 15-k of the word taken for that frame, so the most significant bit goes first.
- R2: `smp_ready` is high exactly in the cycle before a frame begins. That is the last cycle of a running frame, or a cycle whose closing edge samples an aligning event. A word is taken only when `smp_valid` is also high. If it is low, the coming slot leaves `sdo_oe` low.
- R3: `sdo_oe` is high only inside the device's slot, and `sdo` reads 0 whenever `sdo_oe` is low.
- R4: `fs_out` is high in frame cycles 15 to 30 and low otherwise. A second device fed from it therefore starts its slot at cycle 16 of the first device's frame.
- R5: An edge on `fs_in` (sampled high after being sampled low) aligns the frame only while armed. Reset and each resynchronise edge arm it, and an accepted frame-sync edge disarms it. Frame-sync edges while disarmed have no effect.
- R6: Every rising edge on `resync` aligns the frame and arms the frame-sync input. This holds even when it coincides with a frame-sync edge.
- R7: After any aligning event, `dvalid` is low for the first SETTLE_FRAMES frames and high from the following frame start. It changes only on an edge that ends a `smp_ready` cycle.
- R8: `sdo_oe` is never high while `dvalid` is low. Two chained devices given the same `resync` pulse therefore never drive the line together.
- R9: From reset until the first aligning event, `fs_out`, `sdo_oe`, `sdo` and `dvalid` stay low.
- R10: Pulsing the master `fs_in` once per frame, in the last frame cycle, gives the same bus activity as a single pulse after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fs_in | input | 1 | Frame-sync input, edge-detected, honoured only while armed |
| resync | input | 1 | Resynchronise input, edge-detected, always realigns |
| smp_valid | input | 1 | Result word offered by the filter model |
| smp_ready | output | 1 | Port takes a word at the next edge if valid |
| smp_data | input | WORD_W | Parallel result word |
| sdo | output | 1 | Serial data, MSB first, 0 when not driving |
| sdo_oe | output | 1 | Drive enable for the shared serial line |
| fs_out | output | 1 | Frame-sync output, high ahead of and across the second half-frame |
| dvalid | output | 1 | Current frame result has settled |

## Verification
A master and a slave copy run chained on one resolved line. A behavioural model of both devices is compared with every output on every clock. The first run gives a single frame-sync pulse. The results are then compared with per-frame in-phase pulses, which must give identical bus traffic. Frame-sync pulses at odd phases follow; they must be ignored, which separates the once-only rule from a naive realign. Resynchronise pulses at several phases show that realignment happens each time. A frame-sync pulse shortly after a resynchronise shows that arming returns. A stalled source frame shows that an untaken word releases the slot rather than repeating stale data.

// File: rtl/sbsp_pkg.sv
package sbsp_pkg;

  typedef enum logic [1:0] {
    ALIGN_NONE,
    ALIGN_FS,
    ALIGN_RESYNC
  } align_src_e;

endpackage

// File: rtl/sbsp_sync.sv
module sbsp_sync
  import sbsp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fs_in,
  input  logic       resync,
  output align_src_e src
);

  logic fs_q, rs_q, armed;
  logic fs_rise, rs_rise;

  always_comb begin
    fs_rise = fs_in & ~fs_q;
    rs_rise = resync & ~rs_q;
    if (rs_rise)             src = ALIGN_RESYNC;
    else if (fs_rise && armed) src = ALIGN_FS;
    else                     src = ALIGN_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q  <= 1'b0;
      rs_q  <= 1'b0;
      armed <= 1'b1;
    end else begin
      fs_q <= fs_in;
      rs_q <= resync;
      if (src == ALIGN_RESYNC)  armed <= 1'b1;
      else if (src == ALIGN_FS) armed <= 1'b0;
    end
  end

endmodule

// File: rtl/sbsp_frame_timer.sv
module sbsp_frame_timer #(
  parameter int WORD_W        = 16,
  parameter int SETTLE_FRAMES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic align,
  output logic frame_start,
  output logic in_slot,
  output logic fs_out,
  output logic dvalid
);

  localparam int FRAME_LEN = 2 * WORD_W;
  localparam int CNT_W     = $clog2(FRAME_LEN);
  localparam int SET_W     = $clog2(SETTLE_FRAMES + 2);
  localparam logic [CNT_W-1:0] LAST     = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] SLOT_END = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] FS_FIRST = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] FS_LAST  = CNT_W'(FRAME_LEN - 2);

  logic             running;
  logic [CNT_W-1:0] cnt;
  logic [SET_W-1:0] settle;
  logic             wrap;

  always_comb begin
    wrap        = running && (cnt == LAST);
    frame_start = align || wrap;
    in_slot     = running && (cnt < SLOT_END);
    fs_out      = running && (cnt >= FS_FIRST) && (cnt <= FS_LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt     <= '0;
      settle  <= '0;
      dvalid  <= 1'b0;
    end else if (align) begin
      running <= 1'b1;
      cnt     <= '0;
      settle  <= SET_W'(SETTLE_FRAMES);
      dvalid  <= 1'b0;
    end else if (running) begin
      if (wrap) begin
        cnt    <= '0;
        dvalid <= (settle <= SET_W'(1));
        if (settle != '0) settle <= settle - SET_W'(1);
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/sbsp_shifter.sv
module sbsp_shifter #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              smp_valid,
  input  logic [WORD_W-1:0] smp_data,
  input  logic              in_slot,
  input  logic              dvalid,
  output logic              sdo,
  output logic              sdo_oe
);

  logic [WORD_W-1:0] shreg;
  logic              have;

  always_comb begin
    sdo_oe = in_slot && have && dvalid;
    sdo    = sdo_oe && shreg[WORD_W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      have  <= 1'b0;
    end else if (take) begin
      have <= smp_valid;
      if (smp_valid) shreg <= smp_data;
    end else if (in_slot) begin
      shreg <= {shreg[WORD_W-2:0], 1'b0};
    end
  end

endmodule

// File: rtl/shared_bus_serial_port.sv
module shared_bus_serial_port
  import sbsp_pkg::*;
#(
  parameter int WORD_W        = 16,
  parameter int SETTLE_FRAMES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fs_in,
  input  logic              resync,
  input  logic              smp_valid,
  output logic              smp_ready,
  input  logic [WORD_W-1:0] smp_data,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              fs_out,
  output logic              dvalid
);

  align_src_e src;
  logic       align, frame_start, in_slot;

  assign align     = (src != ALIGN_NONE);
  assign smp_ready = frame_start;

  sbsp_sync u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .fs_in  (fs_in),
    .resync (resync),
    .src    (src)
  );

  sbsp_frame_timer #(
    .WORD_W        (WORD_W),
    .SETTLE_FRAMES (SETTLE_FRAMES)
  ) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .align       (align),
    .frame_start (frame_start),
    .in_slot     (in_slot),
    .fs_out      (fs_out),
    .dvalid      (dvalid)
  );

  sbsp_shifter #(
    .WORD_W (WORD_W)
  ) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (frame_start),
    .smp_valid (smp_valid),
    .smp_data  (smp_data),
    .in_slot   (in_slot),
    .dvalid    (dvalid),
    .sdo       (sdo),
    .sdo_oe    (sdo_oe)
  );

endmodule

// File: rtl/sbsp_checker.sv
module sbsp_checker (
  input logic clk,
  input logic rst_n,
  input logic smp_ready,
  input logic sdo,
  input logic sdo_oe,
  input logic fs_out,
  input logic dvalid
);

  logic seen_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_start <= 1'b0;
    else if (smp_ready) seen_start <= 1'b1;
  end

  // R3: a released line reads zero
  p_quiet_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_oe |-> !sdo);

  // R4: no driving once the second half-frame is under way
  p_silent_second_half_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_out && $past(fs_out)) |-> !sdo_oe);

  // R7: validity moves only at a frame start
  p_dvalid_at_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dvalid) |-> $past(smp_ready));

  // R8: unsettled results never reach the line
  p_drive_needs_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe |-> dvalid);

  // R9: idle until the first frame begins
  p_idle_before_align_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_start |-> (!fs_out && !sdo_oe && !dvalid));

endmodule

bind shared_bus_serial_port sbsp_checker u_sbsp_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .smp_ready (smp_ready),
  .sdo       (sdo),
  .sdo_oe    (sdo_oe),
  .fs_out    (fs_out),
  .dvalid    (dvalid)
);

// File: tb/shared_bus_serial_port_tb.sv
`timescale 1ns/1ps
module shared_bus_serial_port_tb;

  localparam int W      = 16;
  localparam int SETTLE = 3;
  localparam int FRAME  = 2 * W;
  localparam int HALF   = W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic         fs_m = 1'b0;
  logic         resync = 1'b0;
  logic [1:0]   sv = 2'b11;
  logic [W-1:0] sd0, sd1;
  wire  [1:0]   rdy, sdo, oe, fso, dv;

  shared_bus_serial_port #(.WORD_W(W), .SETTLE_FRAMES(SETTLE)) u_dut (
    .clk(clk), .rst_n(rst_n), .fs_in(fs_m), .resync(resync),
    .smp_valid(sv[0]), .smp_ready(rdy[0]), .smp_data(sd0),
    .sdo(sdo[0]), .sdo_oe(oe[0]), .fs_out(fso[0]), .dvalid(dv[0]));

  shared_bus_serial_port #(.WORD_W(W), .SETTLE_FRAMES(SETTLE)) u_slave (
    .clk(clk), .rst_n(rst_n), .fs_in(fso[0]), .resync(resync),
    .smp_valid(sv[1]), .smp_ready(rdy[1]), .smp_data(sd1),
    .sdo(sdo[1]), .sdo_oe(oe[1]), .fs_out(fso[1]), .dvalid(dv[1]));

  int n_chk = 0, n_err = 0;
  bit chk_en = 1'b0, done = 1'b0;
  string scen = "reset";

  // behavioural model of both devices
  int m_run[2], m_cnt[2], m_armed[2], m_fsq[2], m_rsq[2], m_set[2], m_dv[2], m_have[2], n_take[2];
  logic [W-1:0] m_word[2];

  function automatic logic [W-1:0] src_word(int d, int n);
    return W'(n * 40503 + d * 21845 + 4660);
  endfunction

  function automatic bit exp_fso(int d);
    return m_run[d] != 0 && m_cnt[d] >= HALF - 1 && m_cnt[d] <= FRAME - 2;
  endfunction
  function automatic bit exp_oe(int d);
    return m_run[d] != 0 && m_cnt[d] < HALF && m_have[d] != 0 && m_dv[d] != 0;
  endfunction
  function automatic bit exp_sdo(int d);
    return exp_oe(d) ? m_word[d][W-1-m_cnt[d]] : 1'b0;
  endfunction
  function automatic bit fs_seen(int d);
    return (d == 0) ? fs_m : exp_fso(0);
  endfunction
  function automatic bit exp_align(int d);
    return (resync && m_rsq[d] == 0) || (fs_seen(d) && m_fsq[d] == 0 && m_armed[d] != 0);
  endfunction
  function automatic bit exp_ready(int d);
    return exp_align(d) || (m_run[d] != 0 && m_cnt[d] == FRAME - 1);
  endfunction

  task automatic model_reset();
    for (int d = 0; d < 2; d++) begin
      m_run[d] = 0; m_cnt[d] = 0; m_armed[d] = 1; m_fsq[d] = 0; m_rsq[d] = 0;
      m_set[d] = 0; m_dv[d] = 0; m_have[d] = 0; m_word[d] = '0;
    end
  endtask

  initial begin
    model_reset();
    n_take[0] = 0; n_take[1] = 0;
    sd0 = src_word(0, 0);
    sd1 = src_word(1, 0);
  end

  always @(posedge clk) begin
    bit rr[2], fa[2], al[2], st[2], fin[2];
    if (!rst_n) model_reset();
    else begin
      for (int d = 0; d < 2; d++) begin
        fin[d] = fs_seen(d);
        rr[d]  = resync && m_rsq[d] == 0;
        fa[d]  = fin[d] && m_fsq[d] == 0 && m_armed[d] != 0;
        al[d]  = rr[d] || fa[d];
        st[d]  = al[d] || (m_run[d] != 0 && m_cnt[d] == FRAME - 1);
      end
      for (int d = 0; d < 2; d++) begin
        if (st[d]) begin
          m_have[d] = sv[d];
          if (sv[d]) begin
            m_word[d] = (d == 0) ? sd0 : sd1;
            n_take[d]++;
            if (d == 0) sd0 <= src_word(0, n_take[0]);
            else        sd1 <= src_word(1, n_take[1]);
          end
        end
        if (al[d]) begin
          m_run[d] = 1; m_cnt[d] = 0; m_set[d] = SETTLE; m_dv[d] = 0;
        end else if (m_run[d] != 0) begin
          if (m_cnt[d] == FRAME - 1) begin
            m_cnt[d] = 0;
            m_dv[d]  = (m_set[d] <= 1) ? 1 : 0;
            if (m_set[d] > 0) m_set[d]--;
          end else m_cnt[d]++;
        end
        if (rr[d]) m_armed[d] = 1;
        else if (fa[d]) m_armed[d] = 0;
        m_fsq[d] = fin[d];
        m_rsq[d] = resync;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int d, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s [phase %s] dev%0d: actual %0h expected %0h", req, scen, d, act, exp);
    end
  endtask

  // per-cycle comparison, sampled 1 ns after the falling edge
  always @(negedge clk) begin
    #1;
    if (chk_en) begin
      for (int d = 0; d < 2; d++) begin
        chk(rdy[d] == exp_ready(d), "R2 smp_ready", d, rdy[d], exp_ready(d));
        chk(oe[d]  == exp_oe(d),    "R3 sdo_oe",    d, oe[d],  exp_oe(d));
        chk(sdo[d] == exp_sdo(d),   "R1 sdo",       d, sdo[d], exp_sdo(d));
        chk(fso[d] == exp_fso(d),   "R4 fs_out",    d, fso[d], exp_fso(d));
        chk(dv[d]  == m_dv[d][0],   "R7 dvalid",    d, dv[d],  m_dv[d]);
      end
      chk(!(oe[0] && oe[1]), "R8 single driver", 2, oe, 0);
      chk((sdo[0] | sdo[1]) == (exp_sdo(0) | exp_sdo(1)), "R1 shared line", 2,
          sdo[0] | sdo[1], exp_sdo(0) | exp_sdo(1));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic pulse_fs();
    @(negedge clk); fs_m = 1'b1;
    @(negedge clk); fs_m = 1'b0;
  endtask
  task automatic pulse_rs();
    @(negedge clk); resync = 1'b1;
    @(negedge clk); resync = 1'b0;
  endtask
  task automatic fs_in_phase();
    @(negedge clk);
    while (m_cnt[0] != FRAME - 1) @(negedge clk);
    fs_m = 1'b1;
    @(negedge clk); fs_m = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: run did not complete (all requirements)");
      summary();
      $finish;
    end
  end

  initial begin
    cyc(4);
    rst_n = 1'b1;
    chk_en = 1'b1;
    scen = "R9";
    cyc(20);
    #1;
    chk(fso == 2'b00 && oe == 2'b00 && dv == 2'b00 && rdy == 2'b00, "R9 idle after reset", 2,
        {fso, oe, dv, rdy}, 0);

    scen = "R7 first align";
    pulse_fs();
    cyc(FRAME * 6);

    scen = "R10";
    for (int i = 0; i < 4; i++) fs_in_phase();
    cyc(FRAME * 2);

    scen = "R5";
    cyc(9);  pulse_fs(); cyc(FRAME * 2);
    cyc(20); pulse_fs(); cyc(FRAME * 2);

    scen = "R2 stall";
    @(negedge clk);
    while (m_cnt[0] != 20) @(negedge clk);
    sv = 2'b00;
    cyc(FRAME);
    sv = 2'b11;
    cyc(FRAME * 2);

    scen = "R6 first";
    cyc(5);  pulse_rs(); cyc(FRAME * 6);
    scen = "R6 second";
    cyc(11); pulse_rs(); cyc(FRAME * 5);

    scen = "R6 rearm";
    cyc(3); pulse_rs(); cyc(5); pulse_fs(); cyc(FRAME * 6);
    scen = "R5 after rearm";
    cyc(7); pulse_fs(); cyc(FRAME * 3);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule